// File: doc/BRIEF.md
# Serial Page-Buffer Command Engine

This block is the serial slave front end and operation sequencer of a small page-organised memory. A host drives an SPI mode-0 bus (clock idles low, data sampled on the rising edge) and sends a one-byte opcode followed by three address bytes. When chip select is released, the block runs the operation against an internal page array and two page buffers, all of them small register arrays. Two operations are supported. A page/buffer compare reports whether a stored page equals a buffer. An auto rewrite copies a page into a buffer and then programs that buffer back into the same page. A status-read opcode returns a status byte that holds a ready flag and the outcome of the last compare. A separate ready/busy pin shows the same ready flag.

The page size is set by an input that selects between a standard and a binary layout. The layout decides which address bits carry the page number and how many bytes an operation touches (nine and eight with the default parameters, which stand in for a page of 528 bytes and a page of 512 bytes). All serial inputs are synchronised to the system clock. Each byte of a compare or a copy takes one clock. Each byte of the program phase takes `PROG_WAIT` clocks. The busy time is therefore exact and fixed.

The sequencer has four states. IDLE leaves on a launch: a compare goes to CMP and a rewrite goes to XFER. CMP returns to IDLE after its last byte and records the result. XFER moves to PROG after its last byte. PROG returns to IDLE once the wait of its last byte has run out.

Top module: `pagebuf_cmd_engine`

## Requirements
- R1: After reset the ready/busy output is 1. A status read returns 8'h80: bit 7 is 1 for ready, bit 6 is 0, and bits 5..0 are always 0.
- R2: Opcode 8'h60 compares the addressed page with buffer 1, and 8'h61 compares it with buffer 2. Status bit 6 becomes 0 when every byte matches and 1 on any mismatch. After reset, page p byte i holds (37p+11i+3) mod 256. Buffer 2 holds page 1. Buffer 1 holds page 0 in bytes below BIN_BYTES and the bitwise complement of page 0 in the bytes above.
- R3: With size_bin=0 the page number is taken from bits 21..10 of the 24-bit address (sent MSB first after the opcode), and an operation covers STD_BYTES bytes.
- R4: With size_bin=1 the page number is taken from address bits 20..9, and an operation covers BIN_BYTES bytes.
- R5: While an operation runs, rdy_busy_n is 0 and status bit 7 reads 0. A compare keeps rdy_busy_n low for exactly as many clock cycles as its page has bytes.
- R6: Opcode 8'h58 (buffer 1) or 8'h59 (buffer 2) copies the page into the buffer and then programs the buffer back into the page. Busy lasts B + B*PROG_WAIT cycles, where B is the byte count. Afterwards a compare of that page with that buffer matches.
- R7: An operation starts only on the rising edge of chip select, and only if exactly 32 bits were clocked in. With fewer or more bits the command is ignored: no busy and no status change.
- R8: A 32-bit command whose opcode is none of the four operation codes is ignored.
- R9: A compare or rewrite command that completes while the device is busy is ignored. A status read still works while busy.
- R10: Opcode 8'hD7 is the status read. It drives the status byte MSB first on spi_so, from the rising edge of the eighth opcode bit onward. The byte repeats, freshly sampled, for as long as chip select stays low. spi_so changes only after a rising SCK edge, or after chip select goes high (it then reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out (status read) |
| size_bin | input | 1 | Page-size layout: 0 standard, 1 binary |
| rdy_busy_n | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
The compares are run against pages that match and pages that differ only in the byte above BIN_BYTES. This separates the two page lengths. The same address bytes are sent in both layouts, so a wrong choice of page bits shows up as a different page being compared. Rewrites are checked through later compares. A binary-size rewrite leaves the extra standard byte of the buffer untouched, which shows how many bytes were copied. Commands with 24 and 33 bits, an unknown opcode, and a compare sent in the middle of a rewrite must all leave the busy time and status bit 6 unchanged.

// File: rtl/pagebuf_pkg.sv
package pagebuf_pkg;

    localparam logic [7:0] OPC_CMP_B1  = 8'h60;
    localparam logic [7:0] OPC_CMP_B2  = 8'h61;
    localparam logic [7:0] OPC_RWR_B1  = 8'h58;
    localparam logic [7:0] OPC_RWR_B2  = 8'h59;
    localparam logic [7:0] OPC_STATUS  = 8'hD7;
    localparam int         CMD_BITS    = 32;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CMP,
        OP_RWR
    } op_kind_t;

    typedef struct packed {
        op_kind_t    kind;
        logic        bsel;      // 0: buffer 1, 1: buffer 2
        logic        std_size;  // 1: standard page length
        logic [11:0] page;
    } cmd_t;

    // Power-up content of page p, byte i
    function automatic logic [7:0] page_seed(input int p, input int i);
        int v;
        v = (p * 37 + i * 11 + 3) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/pagebuf_spi_front.sv
module pagebuf_spi_front
    import pagebuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_si,
    input  logic       size_bin,
    input  logic [7:0] status_in,
    input  logic       busy,
    output logic       cmd_valid,
    output cmd_t       cmd_q,
    output logic       spi_so
);

    localparam int CNT_W = $clog2(CMD_BITS) + 2;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_BITS);

    logic [2:0] sck_s, cs_s;
    logic [1:0] si_s;
    logic       sck_rise, cs_rise, cs_hi, si_v;

    logic [CMD_BITS-1:0] shreg;
    logic [CNT_W-1:0]    bit_cnt;
    logic                rd_active;
    logic [7:0]          out_sh;
    logic [2:0]          out_cnt;

    logic [7:0]  opcode;
    logic [23:0] addr;
    logic [11:0] page_sel;
    op_kind_t    kind;
    logic        launch;
    logic        unused_addr;

    // Synchronisers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s <= '0;
            cs_s  <= 3'b111;
            si_s  <= '0;
        end else begin
            sck_s <= {sck_s[1:0], spi_sck};
            cs_s  <= {cs_s[1:0], spi_cs_n};
            si_s  <= {si_s[0], spi_si};
        end
    end

    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign cs_rise  = cs_s[1] & ~cs_s[2];
    assign cs_hi    = cs_s[1];
    assign si_v     = si_s[1];

    // Command shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (cs_hi) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[CMD_BITS-2:0], si_v};
            if (bit_cnt != CNT_MAX)
                bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    // Status byte output, shifted after each rising SCK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            out_sh    <= '0;
            out_cnt   <= '0;
        end else if (cs_hi) begin
            rd_active <= 1'b0;
        end else if (sck_rise) begin
            if (bit_cnt == CNT_W'(7) && {shreg[6:0], si_v} == OPC_STATUS) begin
                rd_active <= 1'b1;
                out_sh    <= status_in;
                out_cnt   <= '0;
            end else if (rd_active) begin
                out_sh  <= (out_cnt == 3'd7) ? status_in : {out_sh[6:0], 1'b0};
                out_cnt <= out_cnt + 3'd1;
            end
        end
    end

    assign spi_so = rd_active & out_sh[7];

    // Decode at chip-select release
    assign opcode      = shreg[31:24];
    assign addr        = shreg[23:0];
    assign page_sel    = size_bin ? addr[20:9] : addr[21:10];
    assign unused_addr = ^{addr[23:22], addr[8:0]};

    always_comb begin
        case (opcode)
            OPC_CMP_B1, OPC_CMP_B2: kind = OP_CMP;
            OPC_RWR_B1, OPC_RWR_B2: kind = OP_RWR;
            default:                kind = OP_NONE;
        endcase
    end

    assign launch = cs_rise && (bit_cnt == CNT_FULL) && (kind != OP_NONE) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_q     <= '{kind: OP_NONE, bsel: 1'b0, std_size: 1'b1, page: '0};
        end else begin
            cmd_valid <= launch;
            if (launch)
                cmd_q <= '{kind: kind, bsel: opcode[0], std_size: ~size_bin, page: page_sel};
        end
    end

    // R7: a launch pulse only follows a chip-select release
    a_r7_launch_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cs_rise));

    // R10: serial output moves only after a rising SCK or a deselect
    a_r10_so_moves_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_so) |-> $past(sck_rise || cs_hi));

endmodule

// File: rtl/pagebuf_engine.sv
module pagebuf_engine
    import pagebuf_pkg::*;
#(
    parameter int PAGES     = 4,
    parameter int BIN_BYTES = 8,
    parameter int STD_BYTES = 9,
    parameter int PROG_WAIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cmd_t cmd,
    output logic busy,
    output logic cmp_flag
);

    localparam int PA_W   = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int IDX_W  = (STD_BYTES > 1) ? $clog2(STD_BYTES) : 1;
    localparam int WAIT_W = $clog2(PROG_WAIT + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(PROG_WAIT - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMP,
        ST_XFER,
        ST_PROG
    } state_t;

    state_t state_q, state_d;

    logic [7:0] mem  [PAGES][STD_BYTES];
    logic [7:0] bufs [2][STD_BYTES];

    logic [PA_W-1:0]   pg_q;
    logic              bsel_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [WAIT_W-1:0] wait_q;
    logic              miss_q, cmp_flag_q;
    logic              at_last, wait_done, byte_diff;
    logic [7:0]        mem_byte, buf_byte;
    logic              unused_page;

    assign unused_page = ^cmd.page;
    assign mem_byte    = mem[pg_q][idx_q];
    assign buf_byte    = bufs[bsel_q][idx_q];
    assign byte_diff   = (mem_byte != buf_byte);
    assign at_last     = (idx_q == last_q);
    assign wait_done   = (wait_q == WAIT_LAST);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (cmd.kind == OP_CMP) ? ST_CMP : ST_XFER;
            ST_CMP:  if (at_last) state_d = ST_IDLE;
            ST_XFER: if (at_last) state_d = ST_PROG;
            ST_PROG: if (at_last && wait_done) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and arrays
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q       <= '0;
            bsel_q     <= 1'b0;
            idx_q      <= '0;
            last_q     <= '0;
            wait_q     <= '0;
            miss_q     <= 1'b0;
            cmp_flag_q <= 1'b0;
            for (int p = 0; p < PAGES; p++)
                for (int i = 0; i < STD_BYTES; i++)
                    mem[p][i] <= page_seed(p, i);
            for (int i = 0; i < STD_BYTES; i++) begin
                bufs[0][i] <= (i < BIN_BYTES) ? page_seed(0, i) : ~page_seed(0, i);
                bufs[1][i] <= page_seed(1, i);
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pg_q   <= cmd.page[PA_W-1:0];
                        bsel_q <= cmd.bsel;
                        last_q <= cmd.std_size ? IDX_W'(STD_BYTES - 1) : IDX_W'(BIN_BYTES - 1);
                        idx_q  <= '0;
                        wait_q <= '0;
                        miss_q <= 1'b0;
                    end
                end
                ST_CMP: begin
                    miss_q <= miss_q | byte_diff;
                    idx_q  <= idx_q + IDX_W'(1);
                    if (at_last)
                        cmp_flag_q <= miss_q | byte_diff;
                end
                ST_XFER: begin
                    bufs[bsel_q][idx_q] <= mem_byte;
                    idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
                end
                ST_PROG: begin
                    if (wait_done) begin
                        wait_q <= '0;
                        mem[pg_q][idx_q] <= buf_byte;
                        idx_q <= idx_q + IDX_W'(1);
                    end else begin
                        wait_q <= wait_q + WAIT_W'(1);
                    end
                end
            endcase
        end
    end

    // Outputs
    assign busy     = (state_q != ST_IDLE);
    assign cmp_flag = cmp_flag_q;

    // R9: the decoder never launches into a running operation
    a_r9_start_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == ST_IDLE));

    // R6: the program phase is only entered from the copy phase
    a_r6_prog_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> $past(state_q) == ST_XFER);

    // R2: the compare result only moves as a compare ends
    a_r2_flag_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> $stable(cmp_flag_q));

    // R5: the byte index never runs past the page length
    a_r5_index_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP || state_q == ST_XFER) |-> (idx_q <= last_q));

endmodule

// File: rtl/pagebuf_cmd_engine.sv
module pagebuf_cmd_engine
    import pagebuf_pkg::*;
#(
    parameter int PAGES     = 4,
    parameter int BIN_BYTES = 8,
    parameter int STD_BYTES = 9,
    parameter int PROG_WAIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    output logic spi_so,
    input  logic size_bin,
    output logic rdy_busy_n
);

    logic       busy, cmp_flag, cmd_valid;
    cmd_t       cmd;
    logic [7:0] status;

    assign status     = {~busy, cmp_flag, 6'b0};
    assign rdy_busy_n = ~busy;

    pagebuf_spi_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_si    (spi_si),
        .size_bin  (size_bin),
        .status_in (status),
        .busy      (busy),
        .cmd_valid (cmd_valid),
        .cmd_q     (cmd),
        .spi_so    (spi_so)
    );

    pagebuf_engine #(
        .PAGES     (PAGES),
        .BIN_BYTES (BIN_BYTES),
        .STD_BYTES (STD_BYTES),
        .PROG_WAIT (PROG_WAIT)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_valid),
        .cmd      (cmd),
        .busy     (busy),
        .cmp_flag (cmp_flag)
    );

endmodule

// File: tb/tb_pagebuf_cmd_engine.sv
module tb_pagebuf_cmd_engine;

    localparam int W = 64;

    logic clk = 1'b0;
    logic rst_n, spi_sck, spi_cs_n, spi_si, size_bin;
    logic spi_so, rdy_busy_n;

    always #10 clk = ~clk;

    pagebuf_cmd_engine #(.PAGES(4), .BIN_BYTES(8), .STD_BYTES(9), .PROG_WAIT(W)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_so(spi_so), .size_bin(size_bin), .rdy_busy_n(rdy_busy_n)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] act_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int busy_cnt = 0;

    always @(negedge clk) if (rst_n && !rdy_busy_n) busy_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops captured status bytes and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_t       e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(e.tag, int'(a), int'(e.val));
            end
        end
    end

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk);
        spi_si = b;
        repeat (3) @(negedge clk);
        r = spi_so;
        spi_sck = 1'b1;
        repeat (4) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    task automatic cs_low;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_high;
        repeat (3) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [23:0] addr, input int nbits);
        logic [31:0] d;
        logic        r;
        d = {op, addr};
        cs_low();
        for (int i = 0; i < nbits; i++)
            spi_bit((i < 32) ? d[31-i] : 1'b0, r);
        cs_high();
    endtask

    task automatic read_status(input string tag, input logic [7:0] exp, input int nbytes);
        logic       r;
        logic [7:0] got;
        cs_low();
        for (int i = 7; i >= 0; i--) spi_bit(pagebuf_pkg::OPC_STATUS[i], r);
        for (int b = 0; b < nbytes; b++) begin
            got = '0;
            for (int i = 0; i < 8; i++) begin
                spi_bit(1'b0, r);
                got = {got[6:0], r};
            end
            exp_q.push_back('{val: exp, tag: tag});
            act_q.push_back(got);
        end
        cs_high();
    endtask

    task automatic wait_idle;
        repeat (8) @(negedge clk);
        while (!rdy_busy_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_op(input logic bin, input logic [7:0] op, input logic [23:0] addr,
                          input int nbits, input int exp_busy, input string tag);
        int b0;
        size_bin = bin;
        b0 = busy_cnt;
        send_cmd(op, addr, nbits);
        wait_idle();
        check(tag, busy_cnt - b0, exp_busy);
    endtask

    initial begin
        spi_sck = 0; spi_cs_n = 1; spi_si = 0; size_bin = 0; rst_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        check("R1 ready after reset", int'(rdy_busy_n), 1);
        read_status("R1 status after reset", 8'h80, 1);

        // Page-size layouts and buffer selection
        run_op(0, 8'h60, 24'h000000, 32, 9, "R5 std compare busy length");
        read_status("R3 std page0 vs buf1 differs in top byte", 8'hC0, 1);
        run_op(1, 8'h60, 24'h000000, 32, 8, "R4 bin compare busy length");
        read_status("R4 bin page0 vs buf1 matches", 8'h80, 1);
        run_op(0, 8'h61, 24'h000400, 32, 9, "R5 std compare buf2 busy");
        read_status("R2 std page1 vs buf2 matches", 8'h80, 1);
        run_op(1, 8'h61, 24'h000400, 32, 8, "R4 bin addr 0x400 busy");
        read_status("R4 bin addr 0x400 selects page2", 8'hC0, 1);
        run_op(1, 8'h61, 24'h000200, 32, 8, "R4 bin addr 0x200 busy");
        read_status("R4 bin addr 0x200 selects page1", 8'h80, 1);
        run_op(0, 8'h61, 24'h000000, 32, 9, "R2 std page0 buf2 busy");
        read_status("R2 std page0 vs buf2 mismatch", 8'hC0, 1);

        // Malformed lengths and unknown opcode
        run_op(0, 8'h61, 24'h000400, 24, 0, "R7 24-bit command no busy");
        read_status("R7 24-bit command no status change", 8'hC0, 1);
        run_op(0, 8'h61, 24'h000400, 33, 0, "R7 33-bit command no busy");
        read_status("R7 33-bit command no status change", 8'hC0, 1);
        run_op(0, 8'h61, 24'h000400, 32, 9, "R7 exact 32 bits runs");
        read_status("R7 exact command result", 8'h80, 1);
        run_op(0, 8'h62, 24'h000000, 32, 0, "R8 unknown opcode no busy");
        read_status("R8 unknown opcode no status change", 8'h80, 1);

        // Standard rewrite through buffer 1, with traffic while busy
        begin
            int b0;
            size_bin = 0;
            b0 = busy_cnt;
            send_cmd(8'h58, 24'h000800, 32);
            read_status("R5 status while busy", 8'h00, 1);
            check("R5 rdy low during rewrite", int'(rdy_busy_n), 0);
            send_cmd(8'h61, 24'h000000, 32);
            wait_idle();
            check("R6 std rewrite busy length", busy_cnt - b0, 9 + 9 * W);
        end
        read_status("R9 compare during busy ignored", 8'h80, 1);
        run_op(0, 8'h60, 24'h000800, 32, 9, "R6 std compare after rewrite busy");
        read_status("R6 buf1 now holds page2", 8'h80, 1);
        run_op(0, 8'h60, 24'h000000, 32, 9, "R6 std compare page0 busy");
        read_status("R6 buf1 no longer page0", 8'hC0, 1);

        // Binary rewrite through buffer 2
        run_op(1, 8'h59, 24'h000600, 32, 8 + 8 * W, "R6 bin rewrite busy length");
        run_op(1, 8'h61, 24'h000600, 32, 8, "R4 bin compare page3 busy");
        read_status("R6 buf2 now holds page3", 8'h80, 1);
        run_op(0, 8'h61, 24'h000C00, 32, 9, "R4 std compare page3 busy");
        read_status("R4 bin rewrite left top byte of buf2", 8'hC0, 1);

        // Repeated status bytes in one selection
        read_status("R10 repeated status byte", 8'hC0, 2);

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule